// File: doc/BRIEF.md
# I2C Target Front End with General Call and High-Speed Code Handling

This block is the bus-facing half of a small peripheral on an I2C bus. It oversamples the clock and data lines with the system clock and finds start, repeated start and stop conditions. It shifts bytes in and out most significant bit first and answers in the ninth clock by pulling the data line low. A register block behind it sees only single-cycle byte strobes. It delivers a write strobe with each accepted data byte, and it raises a read strobe whenever it needs the next byte to send.

The first byte after any start is examined. If it carries the block's own 7-bit address, a normal write or read transfer follows. The all-zero General Call address is always accepted. The data byte after it is then judged by value: the reset code is accepted and produces a one-cycle reset pulse for the peripheral, the second known code is accepted silently, and every other value is refused. A first byte of the form 00001xxx is the high-speed master code. It is never acknowledged, and it sets a high-speed flag that lasts until the next stop. The data line is modelled as an open-drain enable, so the block can only ever pull low.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: Start is taken as SDA falling while SCL is high, and stop as SDA rising while SCL is high. Both are judged on the lines after SYNC_STAGES synchronising flops.
- R2: A first byte equal to {DEV_ADDR, rw} is acknowledged: sda_oe_o is 1 while SCL is high in the ninth clock. The block only starts pulling SDA low while SCL is low.
- R3: A first byte that is not this block's address, not 8'h00 and not a master code is not acknowledged. Until the next start or stop, later bytes get no acknowledge and no strobe.
- R4: After a write address (rw = 0), every data byte is acknowledged. One byte raises wr_stb_o for exactly one cycle, with the byte on wr_data_o.
- R5: After a read address (rw = 1), rd_stb_o pulses for one cycle and rd_data_i is sampled in that cycle. The byte is sent MSB first, with SDA pulled low only for 0 bits. A master acknowledge (SDA low) fetches the next byte. A master no-acknowledge releases SDA.
- R6: The General Call address byte 8'h00 is always acknowledged. The byte 8'h01 is not acknowledged.
- R7: After a General Call address, the data byte 8'h06 is acknowledged and gc_reset_o pulses for exactly one cycle.
- R8: After a General Call address, 8'h04 is acknowledged without a reset pulse. Every other data byte is not acknowledged and gives no pulse.
- R9: A first byte whose top five bits are 00001 is never acknowledged and sets hs_mode_o.
- R10: hs_mode_o stays set through repeated starts and is cleared by the next stop.
- R11: A repeated start in the middle of a byte discards that byte without a strobe and restarts address reception.
- R12: While reset is held and just after it, sda_oe_o, wr_stb_o, rd_stb_o, gc_reset_o and hs_mode_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| wr_stb_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_data_o | output | 8 | Byte delivered with wr_stb_o |
| rd_stb_o | output | 1 | One-cycle request for the next byte to send |
| rd_data_i | input | 8 | Byte to send, sampled with rd_stb_o |
| gc_reset_o | output | 1 | One-cycle full-reset request from General Call |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
On every cycle the assertions check these rules: each strobe and the reset pulse last a single cycle; the block begins pulling SDA low only while the synchronised SCL is low; the high-speed flag never rises while the block is driving SDA; and any stop clears the flag. Whether a byte gets an acknowledge, which General Call values cause a reset, what data a read sends, and how a byte cut short by a repeated start is discarded are all decided by value over whole transfers. Only the bench shows them, by sweeping every first byte and every General Call data byte through a real master sequence.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK
   } tgt_state_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_WDATA,
      BK_GCDATA
   } byte_kind_e;

   localparam logic [4:0] HS_PREFIX = 5'b00001;
   localparam logic [7:0] GC_ADDR   = 8'h00;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_linesync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_ff[g] <= 1'b1;
            sda_ff[g] <= 1'b1;
         end else if (g == 0) begin
            scl_ff[g] <= scl_i;
            sda_ff[g] <= sda_i;
         end else begin
            scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
            sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[STAGES-1];
         sda_q <= sda_ff[STAGES-1];
      end
   end

   assign scl_o      = scl_ff[STAGES-1];
   assign sda_o      = sda_ff[STAGES-1];
   assign scl_rise_o = !scl_q && scl_o;
   assign scl_fall_o = scl_q && !scl_o;
   // R1: conditions need SCL high on both samples around the SDA edge
   assign start_o    = scl_q && scl_o && sda_q && !sda_o;
   assign stop_o     = scl_q && scl_o && !sda_q && sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR      = 7'h48,
   parameter logic [7:0] GC_RESET_CODE = 8'h06,
   parameter logic [7:0] GC_ACK_CODE   = 8'h04,
   parameter int         BITS          = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            stop_i,
   input  logic            scl_rise_i,
   input  logic            scl_fall_i,
   input  logic            sda_i,
   input  logic [BITS-1:0] rd_data_i,
   output logic            sda_oe_o,
   output logic            wr_stb_o,
   output logic [BITS-1:0] wr_data_o,
   output logic            rd_stb_o,
   output logic            gc_reset_o,
   output logic            hs_set_o
);
   localparam int CNT_W = $clog2(BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS-1);

   if (BITS != 8) begin : g_bad_bits
      $error("i2c_tgt_engine: I2C bytes are 8 bits");
   end
   if (DEV_ADDR[6:3] == 4'b0000) begin : g_bad_addr
      $error("i2c_tgt_engine: DEV_ADDR lies in the reserved range");
   end

   tgt_state_e       state;
   byte_kind_e       kind;
   logic [CNT_W-1:0] cnt;
   logic [BITS-1:0]  sh;
   logic             full, ack_q, rd_mode, gc_sel, mack;

   logic [BITS-1:0]  byte_in;
   logic             last_bit;
   assign byte_in  = {sh[BITS-2:0], sda_i};
   assign last_bit = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         kind       <= BK_ADDR;
         cnt        <= '0;
         sh         <= '0;
         full       <= 1'b0;
         ack_q      <= 1'b0;
         rd_mode    <= 1'b0;
         gc_sel     <= 1'b0;
         mack       <= 1'b0;
         wr_stb_o   <= 1'b0;
         wr_data_o  <= '0;
         rd_stb_o   <= 1'b0;
         gc_reset_o <= 1'b0;
         hs_set_o   <= 1'b0;
      end else begin
         wr_stb_o   <= 1'b0;
         rd_stb_o   <= 1'b0;
         gc_reset_o <= 1'b0;
         hs_set_o   <= 1'b0;
         if (start_i) begin
            // R11: any start, repeated or not, drops the byte in progress
            state <= ST_RX;
            kind  <= BK_ADDR;
            cnt   <= '0;
            full  <= 1'b0;
         end else if (stop_i) begin
            state <= ST_IDLE;
            full  <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise_i) begin
                     sh  <= byte_in;
                     cnt <= cnt + 1'b1;
                     if (last_bit) begin
                        full <= 1'b1;
                        unique case (kind)
                           BK_ADDR: begin
                              gc_sel  <= (byte_in == GC_ADDR);
                              rd_mode <= byte_in[0];
                              if (byte_in[7:3] == HS_PREFIX) begin
                                 hs_set_o <= 1'b1;
                                 ack_q    <= 1'b0;
                              end else begin
                                 ack_q <= (byte_in == GC_ADDR) ||
                                          (byte_in[7:1] == DEV_ADDR);
                              end
                           end
                           BK_WDATA:  ack_q <= 1'b1;
                           default:   ack_q <= (byte_in == GC_RESET_CODE) ||
                                               (byte_in == GC_ACK_CODE);
                        endcase
                     end
                  end else if (scl_fall_i && full) begin
                     full <= 1'b0;
                     if (ack_q) begin
                        state <= ST_ACK;
                        if (kind == BK_WDATA) begin
                           wr_stb_o  <= 1'b1;
                           wr_data_o <= sh;
                        end
                        if (kind == BK_GCDATA && sh == GC_RESET_CODE) begin
                           gc_reset_o <= 1'b1;
                        end
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall_i) begin
                     cnt <= '0;
                     if (kind == BK_ADDR && rd_mode && !gc_sel) begin
                        state    <= ST_TX;
                        sh       <= rd_data_i;
                        rd_stb_o <= 1'b1;
                     end else begin
                        state <= ST_RX;
                        if (kind == BK_ADDR) begin
                           kind <= gc_sel ? BK_GCDATA : BK_WDATA;
                        end
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall_i) begin
                     if (last_bit) begin
                        state <= ST_TXACK;
                        cnt   <= '0;
                     end else begin
                        sh  <= {sh[BITS-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise_i) begin
                     mack <= !sda_i;
                  end else if (scl_fall_i) begin
                     if (mack) begin
                        state    <= ST_TX;
                        sh       <= rd_data_i;
                        rd_stb_o <= 1'b1;
                        cnt      <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o = (state == ST_ACK) || (state == ST_TX && !sh[BITS-1]);

   a_r4_wr_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);
   a_r5_rd_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_o |=> !rd_stb_o);
   a_r7_gc_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
      gc_reset_o |=> !gc_reset_o);
endmodule

// File: rtl/i2c_tgt_frontend.sv
module i2c_tgt_frontend #(
   parameter logic [6:0] DEV_ADDR      = 7'h48,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [7:0] GC_RESET_CODE = 8'h06,
   parameter logic [7:0] GC_ACK_CODE   = 8'h04
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   output logic       wr_stb_o,
   output logic [7:0] wr_data_o,
   output logic       rd_stb_o,
   input  logic [7:0] rd_data_i,
   output logic       gc_reset_o,
   output logic       hs_mode_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, hs_set;

   i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_c),
      .stop_o     (stop_c)
   );

   i2c_tgt_engine #(
      .DEV_ADDR      (DEV_ADDR),
      .GC_RESET_CODE (GC_RESET_CODE),
      .GC_ACK_CODE   (GC_ACK_CODE),
      .BITS          (8)
   ) engine_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_c),
      .stop_i     (stop_c),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .sda_i      (sda_s),
      .rd_data_i  (rd_data_i),
      .sda_oe_o   (sda_oe_o),
      .wr_stb_o   (wr_stb_o),
      .wr_data_o  (wr_data_o),
      .rd_stb_o   (rd_stb_o),
      .gc_reset_o (gc_reset_o),
      .hs_set_o   (hs_set)
   );

   // R10: flag survives repeated starts, only a stop clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hs_mode_o <= 1'b0;
      else if (stop_c)  hs_mode_o <= 1'b0;
      else if (hs_set)  hs_mode_o <= 1'b1;
   end

   a_r2_drive_begins_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);
   a_r9_hs_rise_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_mode_o) |-> !sda_oe_o);
   a_r10_hs_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !hs_mode_o);
endmodule

// File: tb/i2c_tgt_frontend_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_frontend_tb_top;
   localparam logic [6:0] DEV  = 7'h48;
   localparam int         HALF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe, wr_stb, rd_stb, gc_reset, hs_mode;
   logic [7:0] wr_data, rd_data;
   logic       sda_bus;

   int checks = 0, errors = 0;
   int wr_cnt = 0, rd_cnt = 0, gc_cnt = 0;
   logic [7:0] wr_last = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] pat(int k);
      return 8'((k * 81 + 60) & 255);
   endfunction
   assign rd_data = pat(rd_cnt);

   i2c_tgt_frontend #(.DEV_ADDR(DEV)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .sda_oe_o   (sda_oe),
      .wr_stb_o   (wr_stb),
      .wr_data_o  (wr_data),
      .rd_stb_o   (rd_stb),
      .rd_data_i  (rd_data),
      .gc_reset_o (gc_reset),
      .hs_mode_o  (hs_mode)
   );

   always @(negedge clk) begin
      if (wr_stb) begin wr_cnt++; wr_last = wr_data; end
      if (rd_stb) rd_cnt++;
      if (gc_reset) gc_cnt++;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(); repeat (HALF) @(negedge clk); endtask
   task automatic gap(); repeat (2) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; hw();
      sda_m = 1'b0; hw();
      scl_m = 1'b0; gap();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; hw();
      scl_m = 1'b1; hw();
      sda_m = 1'b0; hw();
      scl_m = 1'b0; gap();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hw();
      scl_m = 1'b1; hw();
      sda_m = 1'b1; hw();
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hw();
         scl_m = 1'b1; hw();
         scl_m = 1'b0; gap();
      end
   endtask

   task automatic send_byte(logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; hw();
      scl_m = 1'b1; hw();
      ack = !sda_bus;
      scl_m = 1'b0; gap();
   endtask

   task automatic recv_byte(bit give_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; hw();
         scl_m = 1'b1; hw();
         b[i] = sda_bus;
         scl_m = 1'b0; gap();
      end
      sda_m = !give_ack; hw();
      scl_m = 1'b1; hw();
      scl_m = 1'b0; gap();
      sda_m = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      int w0, g0, r0;

      repeat (4) @(negedge clk);
      // R12: quiet during reset
      chk(!sda_oe && !wr_stb && !rd_stb && !gc_reset && !hs_mode, "R12 in reset",
          {sda_oe, wr_stb, rd_stb, gc_reset, hs_mode}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!sda_oe && !hs_mode, "R12 after reset", {sda_oe, hs_mode}, 0);

      // Sweep of every first byte: R2 R3 R6 R9 R10
      for (int v = 0; v < 256; v++) begin
         bit exp_ack, exp_hs;
         exp_hs  = (v[7:3] == 5'b00001);
         exp_ack = (v[7:1] == DEV) || (v == 0);
         bus_start();
         send_byte(8'(v), ack);
         chk(ack == exp_ack, exp_hs ? "R9 hs code nack" :
             (v == 0 ? "R6 gc addr" : (exp_ack ? "R2 own addr" : "R3 foreign addr")),
             ack, exp_ack);
         chk(hs_mode == exp_hs, "R9 hs flag", hs_mode, exp_hs);
         if (v == {DEV, 1'b1}) recv_byte(1'b0, b);
         bus_stop();
         chk(!hs_mode, "R10 hs clear after stop", hs_mode, 0);
      end

      // Sweep of every General Call data byte: R6 R7 R8
      for (int d = 0; d < 256; d++) begin
         bit exp_ack;
         exp_ack = (d == 6) || (d == 4);
         g0 = gc_cnt;
         bus_start();
         send_byte(8'h00, ack);
         chk(ack, "R6 gc addr ack", ack, 1);
         send_byte(8'(d), ack);
         chk(ack == exp_ack, d == 6 ? "R7 gc reset ack" : "R8 gc data ack", ack, exp_ack);
         chk(gc_cnt - g0 == (d == 6 ? 1 : 0), d == 6 ? "R7 gc pulse" : "R8 no pulse",
             gc_cnt - g0, d == 6 ? 1 : 0);
         bus_stop();
      end

      // R4: multi-byte write
      w0 = wr_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      for (int k = 0; k < 4; k++) begin
         logic [7:0] val;
         val = 8'((k * 57 + 13) & 255);
         send_byte(val, ack);
         chk(ack, "R4 data ack", ack, 1);
         chk(wr_last == val && wr_cnt == w0 + k + 1, "R4 write strobe", wr_last, val);
      end
      bus_stop();

      // R5: multi-byte read, master ack then nack
      r0 = rd_cnt;
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk(ack, "R5 read addr ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
         recv_byte(k != 2, b);
         chk(b == pat(r0 + k), "R5 read data", b, pat(r0 + k));
      end
      hw();
      chk(!sda_oe, "R5 released after nack", sda_oe, 0);
      chk(rd_cnt == r0 + 3, "R5 read strobes", rd_cnt - r0, 3);
      bus_stop();

      // R3: after a foreign address, no ack and no effect
      w0 = wr_cnt; g0 = gc_cnt;
      bus_start();
      send_byte(8'hA2, ack);
      send_byte(8'h06, ack);
      chk(!ack, "R3 idle no ack", ack, 0);
      send_byte(8'h00, ack);
      chk(!ack && wr_cnt == w0 && gc_cnt == g0, "R3 idle no strobe", wr_cnt - w0, 0);
      bus_stop();

      // R11: repeated start mid-byte
      w0 = wr_cnt; r0 = rd_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_bits(8'hF0, 5);
      bus_rstart();
      chk(wr_cnt == w0, "R11 partial byte dropped", wr_cnt - w0, 0);
      send_byte({DEV, 1'b1}, ack);
      chk(ack, "R11 address after rstart", ack, 1);
      recv_byte(1'b0, b);
      chk(b == pat(r0), "R11 read after rstart", b, pat(r0));
      bus_stop();

      // R1/R10: hs flag through a repeated start, cleared on stop
      bus_start();
      send_byte(8'h0D, ack);
      chk(!ack && hs_mode, "R9 hs code", {ack, hs_mode}, 1);
      bus_rstart();
      chk(hs_mode, "R10 hs held over rstart", hs_mode, 1);
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R1 start seen in hs", ack, 1);
      send_byte(8'h5A, ack);
      chk(wr_last == 8'h5A, "R4 write in hs", wr_last, 8'h5A);
      bus_stop();
      hw();
      chk(!hs_mode, "R10 hs cleared", hs_mode, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule